// File: doc/BRIEF.md
# Accumulator Lane Saturation Unit

This combinational unit turns a wide per-lane accumulator into a 16-bit result for each of eight lanes. Each lane's accumulator is 48 bits wide and is presented as three 16-bit slices: high, middle and low. The signed 32-bit quantity formed by the high and middle slices decides whether the lane saturates. A shared 2-bit mode input selects how the result is formed.

The unit never writes anything back. It reads the accumulator slices and produces results in the same cycle, so it can sit directly after an accumulator register. The multipliers and the accumulator update logic are outside this unit, and so is the writeback to a register file.

In the low-slice mode the unit signals saturation through unsigned limits, not through the signed ones. An accumulator below the signed range gives 0x0000, and one above the range gives 0xFFFF. If the accumulator is in range, the low slice passes through unchanged.

Top module: `acc_sat_unit`

## Requirements
- R1: The eight lanes are independent and share the single mode input. Lane i uses bits [16i+15:16i] of each slice bus and of the result bus.
- R2: In mode 2'b00 (signed middle), a lane whose {high, middle} value as a signed 32-bit number is below -32768 outputs 0x8000.
- R3: In mode 2'b00, a value above +32767 outputs 0x7FFF. A value inside [-32768, +32767] outputs the middle slice.
- R4: In mode 2'b01 (unsigned middle), a value inside [0, +32767] outputs the middle slice. Any negative value, whether in range or below it, outputs 0x0000.
- R5: In mode 2'b01, a value above +32767 outputs 0xFFFF.
- R6: In mode 2'b10 (low), a value inside [-32768, +32767] outputs the low slice unchanged.
- R7: In mode 2'b10, a value below -32768 outputs 0x0000 and a value above +32767 outputs 0xFFFF.
- R8: In mode 2'b11 (raw), every lane outputs its middle slice with no clamping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 2 | Clamp selection shared by all lanes |
| acc_hi | input | 128 | High accumulator slices (bits 47:32), one per lane |
| acc_mid | input | 128 | Middle accumulator slices (bits 31:16), one per lane |
| acc_lo | input | 128 | Low accumulator slices (bits 15:0), one per lane |
| result | output | 128 | Per-lane 16-bit results |

## Verification
The inline assertions check each lane only when its inputs are in a condition whose outcome is fixed by one requirement. Examples are a high slice that is strictly positive, a high slice below -1, or a high slice of zero with the middle top bit clear. The assertions assume the inputs are fully driven with known values whenever they are evaluated. The bench keeps to this by driving every slice bus on the falling edge. It comes out of reset with all buses at zero, and it samples one time unit after each change. The stimulus sweeps the high slice across -2, -1, 0, 1, 2 and extreme values. At the same time it places the middle slice on both sides of its sign bit, so every saturation boundary is crossed in every mode.

// File: rtl/acc_sat_unit.sv
module acc_sat_unit #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic [1:0]         mode,
  input  logic [LANES*W-1:0] acc_hi,
  input  logic [LANES*W-1:0] acc_mid,
  input  logic [LANES*W-1:0] acc_lo,
  output logic [LANES*W-1:0] result
);
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [W-1:0] hi, mid, lo, sclamp, res;
    logic         under, over, hi_neg, hi_pos;

    assign hi  = acc_hi [g*W +: W];
    assign mid = acc_mid[g*W +: W];
    assign lo  = acc_lo [g*W +: W];

    assign hi_neg = hi[W-1];
    assign hi_pos = !hi[W-1] && (hi != ZERO);

    assign under = (hi_neg && (hi != ONES)) || (hi_neg && !mid[W-1]);
    assign over  = hi_pos || ((hi == ZERO) && mid[W-1]);

    assign sclamp = under ? SMIN : (over ? SMAX : mid);

    always_comb begin
      unique case (mode)
        2'b00: res = sclamp;
        2'b01: res = over ? ONES : (sclamp[W-1] ? ZERO : sclamp);
        2'b10: res = (under || over) ? (sclamp ^ SMIN) : lo;
        default: res = mid;
      endcase
    end

    assign result[g*W +: W] = res;

    always_comb begin
      if (mode == 2'b00 && hi_neg && hi != ONES)
        AST_SIGNED_LOW: assert (result[g*W +: W] == SMIN) else $error("signed low");   // R2
      if (mode == 2'b00 && hi_pos)
        AST_SIGNED_HIGH: assert (result[g*W +: W] == SMAX) else $error("signed high"); // R3
      if (mode == 2'b01 && hi_neg)
        AST_UNSIGNED_NEG: assert (result[g*W +: W] == ZERO) else $error("uns neg");    // R4
      if (mode == 2'b01 && hi_pos)
        AST_UNSIGNED_OVER: assert (result[g*W +: W] == ONES) else $error("uns over");  // R5
      if (mode == 2'b10 && hi == ZERO && !mid[W-1])
        AST_LOW_PASS: assert (result[g*W +: W] == lo) else $error("low pass");         // R6
      if (mode == 2'b10 && hi_neg && hi != ONES)
        AST_LOW_UNDER: assert (result[g*W +: W] == ZERO) else $error("low under");     // R7
      if (mode == 2'b11)
        AST_RAW_MID: assert (result[g*W +: W] == mid) else $error("raw mid");          // R8
    end
  end
endmodule

// File: tb/acc_sat_unit_bench.sv
module acc_sat_unit_bench;
  localparam int LANES = 8;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [LANES*W-1:0] acc_hi = '0, acc_mid = '0, acc_lo = '0;
  logic [LANES*W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] th [LANES];
  logic [15:0] tm [LANES];
  logic [15:0] tl [LANES];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  acc_sat_unit u_acc_sat_unit (
    .mode(mode), .acc_hi(acc_hi), .acc_mid(acc_mid), .acc_lo(acc_lo), .result(result)
  );

  function automatic logic [15:0] model(input logic [1:0] m, input logic [15:0] h,
                                        input logic [15:0] md, input logic [15:0] l);
    logic signed [31:0] v;
    v = $signed({h, md});
    case (m)
      2'b00: model = (v < -32768) ? 16'h8000 : (v > 32767) ? 16'h7FFF : md;
      2'b01: model = (v > 32767) ? 16'hFFFF : (v < 0) ? 16'h0000 : md;
      2'b10: model = (v < -32768) ? 16'h0000 : (v > 32767) ? 16'hFFFF : l;
      default: model = md;
    endcase
  endfunction

  function automatic logic [15:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[31:16];
  endfunction

  task automatic apply_and_check(input logic [1:0] m, input string tag);
    @(negedge clk);
    mode = m;
    for (int i = 0; i < LANES; i++) begin
      acc_hi[i*W +: W]  = th[i];
      acc_mid[i*W +: W] = tm[i];
      acc_lo[i*W +: W]  = tl[i];
    end
    #1;
    for (int i = 0; i < LANES; i++) begin
      logic [15:0] exp;
      exp = model(m, th[i], tm[i], tl[i]);
      checks++;
      if (result[i*W +: W] !== exp) begin
        errors++;
        $display("FAIL %s lane %0d mode %0d hi=%h mid=%h lo=%h: actual %h expected %h",
                 tag, i, m, th[i], tm[i], tl[i], result[i*W +: W], exp);
      end
    end
  endtask

  task automatic load_boundaries();
    th[0] = 16'h0000; tm[0] = 16'h7FFF;
    th[1] = 16'h0000; tm[1] = 16'h8000;
    th[2] = 16'hFFFF; tm[2] = 16'h8000;
    th[3] = 16'hFFFF; tm[3] = 16'h7FFF;
    th[4] = 16'h0001; tm[4] = 16'h0000;
    th[5] = 16'hFFFE; tm[5] = 16'hFFFF;
    th[6] = 16'h7FFF; tm[6] = 16'hFFFF;
    th[7] = 16'h8000; tm[7] = 16'h0000;
    for (int i = 0; i < LANES; i++) tl[i] = 16'h1111 * i[15:0] + 16'h0A05;
  endtask

  task automatic t_reset();
    for (int i = 0; i < LANES; i++) begin th[i] = '0; tm[i] = '0; tl[i] = '0; end
    apply_and_check(2'b00, "R3 reset");
  endtask

  task automatic t_signed();
    load_boundaries();
    apply_and_check(2'b00, "R2 R3");
  endtask

  task automatic t_unsigned();
    load_boundaries();
    apply_and_check(2'b01, "R4 R5");
    th[0] = 16'h0000; tm[0] = 16'h0000;
    th[1] = 16'hFFFF; tm[1] = 16'hFFFF;
    apply_and_check(2'b01, "R4");
  endtask

  task automatic t_low();
    load_boundaries();
    apply_and_check(2'b10, "R6 R7");
  endtask

  task automatic t_raw();
    load_boundaries();
    apply_and_check(2'b11, "R8");
  endtask

  task automatic t_lanes();
    for (int k = 0; k < LANES; k++) begin
      for (int i = 0; i < LANES; i++) begin
        th[i] = (i == k) ? 16'h0002 : 16'h0000;
        tm[i] = 16'h0100 + i[15:0];
        tl[i] = 16'hA000 + i[15:0];
      end
      apply_and_check(2'(k % 3), "R1");
    end
  endtask

  task automatic t_sweep();
    logic [15:0] his [6];
    his[0] = 16'h0000; his[1] = 16'hFFFF; his[2] = 16'h0001;
    his[3] = 16'hFFFE; his[4] = 16'h7FFF; his[5] = 16'h8000;
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < LANES; i++) begin
        logic [15:0] r;
        r = rnd();
        th[i] = (r[2:0] < 3'd6) ? his[r[2:0]] : rnd();
        tm[i] = rnd();
        tl[i] = rnd();
      end
      apply_and_check(2'(n % 4), "R1 sweep");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_signed();
    t_unsigned();
    t_low();
    t_raw();
    t_lanes();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule